// File: doc/BRIEF.md
# Seven-Line Configurable Port Controller with Shared PWM

This block controls a small general-purpose port of seven lines. Each line is set up by one bit in each of five masks: direction, detection link, PWM enable, active level and a user output word. The masks pick what the line does. An output line follows either a key-touch bit from the sensing logic or a bit of the user word. It drives that value as a static level or as a pulsed waveform, with either polarity. A single 8-bit level sets the duty cycle of the waveform for every line at once. Levels near either end of the range hold the waveform flat.

Lines set as inputs are passed through a two-stage synchronizer. Their levels appear in an 8-bit status byte, and any level change raises a one-clock change pulse that a host-notification stage can use.

The configuration words are loaded through a simple select/data write strobe. A strap input taken during reset turns every line into an output, so the port reports key touches with no host attached.

Top module: `gpio_pwm_port`

## Requirements
- R1: After reset with the strap low, the words hold these values: direction 0x00, detection link 0x3F, PWM enable 0x00, active level 0x00, user word 0x00 and PWM level 128. Every line is therefore an input: `pin_oe_o` is 0 and `pin_out_o` is 0.
- R2: If `standalone_i` is 1 while reset is applied, the direction word resets to 0x7F and every other word keeps its R1 value.
- R3: A line whose direction bit is 0 has `pin_oe_o`=0 and `pin_out_o`=0, whatever the other masks hold. A line whose direction bit is 1 has `pin_oe_o`=1.
- R4: An output line takes its source from key-touch bit n when its detection-link bit is 1, and from user bit n when that bit is 0. Line 6 has no key, so a linked line 6 sees an untouched key.
- R5: With PWM disabled, the line drives the active level when its source is 1 and the opposite level when its source is 0. Active-level bit 1 means active-high; bit 0 means active-low.
- R6: With PWM enabled, a line whose source is 1 drives the PWM waveform, inverted when the line is active-low. A line whose source is 0 drives the static inactive level: 0 if active-high, 1 if active-low.
- R7: The PWM counter is 8 bits wide. It is 0 in the first cycle after reset and advances by one every clock, wrapping at 255. In the linear range the waveform is 1 while the counter is below the PWM level.
- R8: PWM levels 0 to 10 give a waveform that is always 0. Levels 250 to 255 give a waveform that is always 1.
- R9: Status bit n shows the level of input line n two clocks after it is applied at `pin_in_i`. Bits of output lines read 0, and bit 7 reads 0.
- R10: `in_change_o` is 1 for exactly one clock when the synchronized level of an input line differs from its value one clock earlier. A level change on an output line raises no pulse.
- R11: A write with `cfg_we_i`=1 takes effect in the cycle after the clock edge. Select codes are: 0 direction, 1 detection link, 2 PWM enable, 3 active level, 4 user word, 5 PWM level. Masks use data bits 6:0. Select codes 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| standalone_i | input | 1 | Strap, sampled during reset, that makes all lines outputs |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Selects which word is written |
| cfg_data_i | input | 8 | Write data |
| key_det_i | input | 6 | Key-touch bits from the sensing logic |
| pin_in_i | input | 7 | Levels seen on the port lines |
| pin_out_o | output | 7 | Value driven on each line |
| pin_oe_o | output | 7 | Output enable for each line |
| in_status_o | output | 8 | Synchronized levels of the input lines |
| in_change_o | output | 1 | One-clock pulse on an input-line level change |

## Verification
Some properties are checked on every cycle. A line that is not enabled never carries a 1. The status byte never shows a bit for an output line or for bit 7. The PWM counter steps by exactly one. The waveform stays flat while the level is in a saturation band. A user-word write is visible on the next cycle. A change pulse always comes with a movement in the status byte.

Other behaviour is shown only by the bench scenarios, which compare against a reference model. These cover the priority between detection link, PWM and polarity on each line, the exact duty cycle, the strap default, the latency of the synchronizer, and the rule that writes with unused select codes change nothing.

// File: rtl/gpio_pwm_pkg.sv
// Shared definitions for the port controller: write-select codes and
// default thresholds of the PWM generator.
package gpio_pwm_pkg;
    typedef enum logic [2:0] {
        SEL_DIR   = 3'd0,
        SEL_LINK  = 3'd1,
        SEL_PWMEN = 3'd2,
        SEL_POL   = 3'd3,
        SEL_USER  = 3'd4,
        SEL_LEVEL = 3'd5
    } cfg_sel_e;

    localparam int DEF_SAT_LO    = 10;
    localparam int DEF_SAT_HI    = 250;
    localparam int DEF_LEVEL_RST = 128;
endpackage

// File: rtl/gpio_cfg_regs.sv
// Holds the per-line configuration masks and the shared PWM level.
// Assumes LINES <= DATA_W and LEVEL_W <= DATA_W. The strap is sampled
// only while reset is applied.
module gpio_cfg_regs
    import gpio_pwm_pkg::*;
#(
    parameter int LINES     = 7,
    parameter int NUM_KEYS  = 6,
    parameter int LEVEL_W   = 8,
    parameter int DATA_W    = 8,
    parameter int LEVEL_RST = DEF_LEVEL_RST
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               standalone_i,
    input  logic               we_i,
    input  logic [2:0]         sel_i,
    input  logic [DATA_W-1:0]  data_i,
    output logic [LINES-1:0]   dir_o,
    output logic [LINES-1:0]   link_o,
    output logic [LINES-1:0]   pwmen_o,
    output logic [LINES-1:0]   pol_o,
    output logic [LINES-1:0]   user_o,
    output logic [LEVEL_W-1:0] level_o
);
    localparam logic [LINES-1:0]   ALL_OUT  = {LINES{1'b1}};
    localparam logic [LINES-1:0]   LINK_RST = LINES'((1 << NUM_KEYS) - 1);
    localparam logic [LEVEL_W-1:0] LVL_RST  = LEVEL_W'(LEVEL_RST);

    logic [LINES-1:0] wmask;
    assign wmask = data_i[LINES-1:0];

    // Reset defaults, strap-selected direction, and select-decoded writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_o   <= standalone_i ? ALL_OUT : '0;
            link_o  <= LINK_RST;
            pwmen_o <= '0;
            pol_o   <= '0;
            user_o  <= '0;
            level_o <= LVL_RST;
        end else if (we_i) begin
            case (cfg_sel_e'(sel_i))
                SEL_DIR:   dir_o   <= wmask;
                SEL_LINK:  link_o  <= wmask;
                SEL_PWMEN: pwmen_o <= wmask;
                SEL_POL:   pol_o   <= wmask;
                SEL_USER:  user_o  <= wmask;
                SEL_LEVEL: level_o <= data_i[LEVEL_W-1:0];
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_pwm_gen.sv
// Free-running counter and a shared duty-cycle comparator with a flat
// band at each end of the level range. Assumes SAT_LO < SAT_HI.
module gpio_pwm_gen
    import gpio_pwm_pkg::*;
#(
    parameter int LEVEL_W = 8,
    parameter int SAT_LO  = DEF_SAT_LO,
    parameter int SAT_HI  = DEF_SAT_HI
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LEVEL_W-1:0] level_i,
    output logic [LEVEL_W-1:0] cnt_o,
    output logic               wave_o
);
    localparam logic [LEVEL_W-1:0] LO_MAX = LEVEL_W'(SAT_LO);
    localparam logic [LEVEL_W-1:0] HI_MIN = LEVEL_W'(SAT_HI);

    logic [LEVEL_W-1:0] cnt_q;

    // Counter advances every clock and wraps at the top of its range.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Saturation bands take precedence over the linear comparison.
    always_comb begin
        if (level_i <= LO_MAX)      wave_o = 1'b0;
        else if (level_i >= HI_MIN) wave_o = 1'b1;
        else                        wave_o = (cnt_q < level_i);
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/gpio_pin_mux.sv
// Per-line resolution of the drive value, in this order: direction,
// then the source choice (key or user bit), then PWM or static, then
// polarity. Purely combinational. Lines at or above NUM_KEYS have no
// key and see it as untouched.
module gpio_pin_mux #(
    parameter int LINES    = 7,
    parameter int NUM_KEYS = 6
) (
    input  logic [LINES-1:0]    dir_i,
    input  logic [LINES-1:0]    link_i,
    input  logic [LINES-1:0]    pwmen_i,
    input  logic [LINES-1:0]    pol_i,
    input  logic [LINES-1:0]    user_i,
    input  logic [NUM_KEYS-1:0] key_i,
    input  logic                wave_i,
    output logic [LINES-1:0]    out_o,
    output logic [LINES-1:0]    oe_o
);
    for (genvar n = 0; n < LINES; n++) begin : g_line
        logic key_n;
        logic src;

        if (n < NUM_KEYS) begin : g_key
            assign key_n = key_i[n];
        end else begin : g_nokey
            assign key_n = 1'b0;
        end

        // The link bit picks the key state or the user bit as source.
        assign src = link_i[n] ? key_n : user_i[n];

        // Turn direction, PWM enable and polarity into the line drive.
        always_comb begin
            oe_o[n] = dir_i[n];
            if (!dir_i[n])      out_o[n] = 1'b0;
            else if (!src)      out_o[n] = ~pol_i[n];
            else if (pwmen_i[n]) out_o[n] = pol_i[n] ? wave_i : ~wave_i;
            else                out_o[n] = pol_i[n];
        end
    end
endmodule

// File: rtl/gpio_in_sampler.sv
// Two-stage synchronizer for the line levels, a status byte masked by
// direction, and change detection against the previous synced value.
// Assumes STATUS_W > LINES so that the top status bits read zero.
module gpio_in_sampler #(
    parameter int LINES    = 7,
    parameter int STATUS_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LINES-1:0]    pin_i,
    input  logic [LINES-1:0]    dir_i,
    output logic [STATUS_W-1:0] status_o,
    output logic                change_o
);
    logic [LINES-1:0] meta_q;
    logic [LINES-1:0] sync_q;
    logic [LINES-1:0] last_q;

    // Synchronizer chain, plus one more stage for the previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            last_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign status_o = STATUS_W'(sync_q & ~dir_i);
    assign change_o = |((sync_q ^ last_q) & ~dir_i);
endmodule

// File: rtl/gpio_pwm_port.sv
// Top of the seven-line port controller. Connects the configuration
// words, the shared PWM generator, the per-line drive mux and the input
// sampler. Pad drivers and the register bus sit outside this block.
module gpio_pwm_port
    import gpio_pwm_pkg::*;
#(
    parameter int LINES     = 7,
    parameter int NUM_KEYS  = 6,
    parameter int LEVEL_W   = 8,
    parameter int DATA_W    = 8,
    parameter int STATUS_W  = 8,
    parameter int SAT_LO    = DEF_SAT_LO,
    parameter int SAT_HI    = DEF_SAT_HI,
    parameter int LEVEL_RST = DEF_LEVEL_RST
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                standalone_i,
    input  logic                cfg_we_i,
    input  logic [2:0]          cfg_sel_i,
    input  logic [DATA_W-1:0]   cfg_data_i,
    input  logic [NUM_KEYS-1:0] key_det_i,
    input  logic [LINES-1:0]    pin_in_i,
    output logic [LINES-1:0]    pin_out_o,
    output logic [LINES-1:0]    pin_oe_o,
    output logic [STATUS_W-1:0] in_status_o,
    output logic                in_change_o
);
    logic [LINES-1:0]   dir_q;
    logic [LINES-1:0]   link_q;
    logic [LINES-1:0]   pwmen_q;
    logic [LINES-1:0]   pol_q;
    logic [LINES-1:0]   user_q;
    logic [LEVEL_W-1:0] level_q;
    logic [LEVEL_W-1:0] pwm_cnt;
    logic               pwm_wave;

    gpio_cfg_regs #(
        .LINES(LINES), .NUM_KEYS(NUM_KEYS), .LEVEL_W(LEVEL_W),
        .DATA_W(DATA_W), .LEVEL_RST(LEVEL_RST)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .standalone_i(standalone_i),
        .we_i(cfg_we_i), .sel_i(cfg_sel_i), .data_i(cfg_data_i),
        .dir_o(dir_q), .link_o(link_q), .pwmen_o(pwmen_q),
        .pol_o(pol_q), .user_o(user_q), .level_o(level_q)
    );

    gpio_pwm_gen #(
        .LEVEL_W(LEVEL_W), .SAT_LO(SAT_LO), .SAT_HI(SAT_HI)
    ) u_pwm (
        .clk(clk), .rst_n(rst_n), .level_i(level_q),
        .cnt_o(pwm_cnt), .wave_o(pwm_wave)
    );

    gpio_pin_mux #(
        .LINES(LINES), .NUM_KEYS(NUM_KEYS)
    ) u_mux (
        .dir_i(dir_q), .link_i(link_q), .pwmen_i(pwmen_q), .pol_i(pol_q),
        .user_i(user_q), .key_i(key_det_i), .wave_i(pwm_wave),
        .out_o(pin_out_o), .oe_o(pin_oe_o)
    );

    gpio_in_sampler #(
        .LINES(LINES), .STATUS_W(STATUS_W)
    ) u_smp (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_in_i), .dir_i(dir_q),
        .status_o(in_status_o), .change_o(in_change_o)
    );
endmodule

// File: rtl/gpio_pwm_checker.sv
// Property checker for the port controller, attached to the top by bind.
// Watches ports and the outputs of the configuration words and the PWM
// generator.
module gpio_pwm_checker #(
    parameter int LINES    = 7,
    parameter int LEVEL_W  = 8,
    parameter int DATA_W   = 8,
    parameter int STATUS_W = 8,
    parameter int SAT_LO   = 10,
    parameter int SAT_HI   = 250
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_we_i,
    input logic [2:0]          cfg_sel_i,
    input logic [DATA_W-1:0]   cfg_data_i,
    input logic [LINES-1:0]    pin_out_o,
    input logic [LINES-1:0]    pin_oe_o,
    input logic [STATUS_W-1:0] in_status_o,
    input logic                in_change_o,
    input logic [LINES-1:0]    dir_q,
    input logic [LINES-1:0]    user_q,
    input logic [LEVEL_W-1:0]  level_q,
    input logic [LEVEL_W-1:0]  pwm_cnt,
    input logic                pwm_wave
);
    localparam logic [LEVEL_W-1:0] LO_MAX = LEVEL_W'(SAT_LO);
    localparam logic [LEVEL_W-1:0] HI_MIN = LEVEL_W'(SAT_HI);

    assert_input_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (~pin_oe_o & pin_out_o) == '0);

    assert_status_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_status_o[LINES-1:0] & pin_oe_o) == '0) && (in_status_o[STATUS_W-1:LINES] == '0));

    assert_counter_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pwm_cnt == LEVEL_W'($past(pwm_cnt) + 1'b1));

    assert_sat_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q <= LO_MAX) |-> !pwm_wave);

    assert_sat_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q >= HI_MIN) |-> pwm_wave);

    assert_change_moves_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_change_o && $stable(dir_q)) |-> !$stable(in_status_o));

    assert_user_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && cfg_sel_i == 3'd4) |=> user_q == $past(cfg_data_i[LINES-1:0]));
endmodule

bind gpio_pwm_port gpio_pwm_checker #(
    .LINES(LINES), .LEVEL_W(LEVEL_W), .DATA_W(DATA_W),
    .STATUS_W(STATUS_W), .SAT_LO(SAT_LO), .SAT_HI(SAT_HI)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_data_i(cfg_data_i), .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o),
    .in_status_o(in_status_o), .in_change_o(in_change_o),
    .dir_q(dir_q), .user_q(user_q), .level_q(level_q),
    .pwm_cnt(pwm_cnt), .pwm_wave(pwm_wave)
);

// File: tb/tb_gpio_pwm_port.sv
// Bench for the port controller. A behavioural model is updated on each
// rising edge and compared with the outputs a quarter period later.
module tb_gpio_pwm_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standalone_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [2:0] cfg_sel_i = 3'd0;
    logic [7:0] cfg_data_i = 8'd0;
    logic [5:0] key_det_i = 6'd0;
    logic [6:0] pin_in_i = 7'd0;
    logic [6:0] pin_out_o;
    logic [6:0] pin_oe_o;
    logic [7:0] in_status_o;
    logic       in_change_o;

    gpio_pwm_port dut (
        .clk(clk), .rst_n(rst_n), .standalone_i(standalone_i),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_data_i(cfg_data_i),
        .key_det_i(key_det_i), .pin_in_i(pin_in_i),
        .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o),
        .in_status_o(in_status_o), .in_change_o(in_change_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    total = 0;
    int    bad = 0;
    string tag = "R1";
    bit    started = 0;
    int    changes_seen = 0;

    // Model state
    int         m_dir, m_link, m_pwmen, m_pol, m_user, m_level, m_cnt;
    logic [6:0] hist[$] = '{7'd0, 7'd0, 7'd0};

    function automatic int model_wave();
        if (m_level <= 10)  return 0;
        if (m_level >= 250) return 1;
        return (m_cnt < m_level) ? 1 : 0;
    endfunction

    function automatic logic [6:0] model_out();
        logic [6:0] r = '0;
        logic [6:0] keys = {1'b0, key_det_i};
        for (int i = 0; i < 7; i++) begin
            int src, hi;
            if (((m_dir >> i) & 1) == 0) continue;
            src = ((m_link >> i) & 1) ? int'(keys[i]) : ((m_user >> i) & 1);
            hi  = (m_pol >> i) & 1;
            if (src == 0)                   r[i] = (hi == 0);
            else if ((m_pwmen >> i) & 1)    r[i] = hi ? (model_wave() == 1) : (model_wave() == 0);
            else                            r[i] = (hi == 1);
        end
        return r;
    endfunction

    // Model update on each edge, then the comparison a quarter period later.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = standalone_i ? 'h7F : 0;
            m_link = 'h3F; m_pwmen = 0; m_pol = 0; m_user = 0;
            m_level = 128; m_cnt = 0;
            hist = '{7'd0, 7'd0, 7'd0};
        end else begin
            m_cnt = (m_cnt + 1) % 256;
            hist.push_front(pin_in_i);
            void'(hist.pop_back());
            if (cfg_we_i) begin
                case (cfg_sel_i)
                    3'd0: m_dir   = cfg_data_i & 'h7F;
                    3'd1: m_link  = cfg_data_i & 'h7F;
                    3'd2: m_pwmen = cfg_data_i & 'h7F;
                    3'd3: m_pol   = cfg_data_i & 'h7F;
                    3'd4: m_user  = cfg_data_i & 'h7F;
                    3'd5: m_level = cfg_data_i;
                    default: ;
                endcase
            end
        end
        started = 1;
        #(CLK_PERIOD/4);
        compare();
    end

    task automatic compare();
        logic [6:0] e_oe   = 7'(m_dir);
        logic [6:0] e_out  = model_out();
        logic [7:0] e_stat = {1'b0, hist[1] & ~e_oe};
        logic       e_chg  = |((hist[1] ^ hist[2]) & ~e_oe);
        total++;
        if (in_change_o) changes_seen++;
        if (pin_oe_o !== e_oe || pin_out_o !== e_out ||
            in_status_o !== e_stat || in_change_o !== e_chg) begin
            bad++;
            $display("FAIL %s t=%0t actual oe=%h out=%h st=%h chg=%b expected oe=%h out=%h st=%h chg=%b",
                     tag, $time, pin_oe_o, pin_out_o, in_status_o, in_change_o,
                     e_oe, e_out, e_stat, e_chg);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] sel, logic [7:0] data);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_data_i = data;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic do_reset(logic strap);
        @(negedge clk);
        rst_n = 1'b0; standalone_i = strap;
        tick(3);
        rst_n = 1'b1; standalone_i = 1'b0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog all requirements actual=running expected=finished");
        summary();
    end

    initial begin
        // R1: defaults after a plain reset: all lines inputs.
        tag = "R1"; do_reset(1'b0); tick(4);
        // R1 and R4: link word defaults to keys 0..5, active-low.
        wr(3'd0, 8'h7F); tick(3);
        tag = "R4"; key_det_i = 6'b000100; tick(3);
        key_det_i = 6'b101001; wr(3'd1, 8'h7F); tick(3);
        wr(3'd1, 8'h00); wr(3'd4, 8'h2A); tick(3);
        wr(3'd4, 8'h55); key_det_i = 6'b111111; tick(3);
        // R5: active-high and mixed polarity in digital mode.
        tag = "R5"; wr(3'd3, 8'h7F); tick(3);
        wr(3'd3, 8'h0F); wr(3'd4, 8'h33); tick(3);
        wr(3'd1, 8'h3C); key_det_i = 6'b010101; tick(3);
        // R6 and R7: PWM on half the lines, linear levels, both polarities.
        tag = "R6"; wr(3'd2, 8'h5A); tick(300);
        tag = "R7"; wr(3'd5, 8'd64); tick(280);
        wr(3'd5, 8'd11); tick(260);
        wr(3'd5, 8'd249); tick(260);
        wr(3'd2, 8'h7F); wr(3'd4, 8'h7F); wr(3'd1, 8'h00); wr(3'd5, 8'd200); tick(260);
        // R8: saturation bands, edges of each band.
        tag = "R8";
        wr(3'd5, 8'd0);   tick(260);
        wr(3'd5, 8'd10);  tick(260);
        wr(3'd5, 8'd250); tick(260);
        wr(3'd5, 8'd255); tick(260);
        // R3: direction 0 overrides every other mask.
        tag = "R3"; wr(3'd3, 8'h55); wr(3'd0, 8'h00); tick(5);
        wr(3'd0, 8'h0F); tick(5);
        // R9: status of input lines, zeros for output lines, latency.
        tag = "R9"; pin_in_i = 7'h7F; tick(4);
        pin_in_i = 7'h26; tick(4);
        wr(3'd0, 8'h00); pin_in_i = 7'h59; tick(4);
        // R10: single change pulse, held level, output-line changes ignored.
        tag = "R10"; changes_seen = 0;
        pin_in_i = 7'h58; tick(6);
        total++;
        if (changes_seen != 1) begin
            bad++;
            $display("FAIL R10 pulse count actual=%0d expected=1", changes_seen);
        end
        wr(3'd0, 8'h70); changes_seen = 0;
        pin_in_i = 7'h28; tick(6);
        total++;
        if (changes_seen != 0) begin
            bad++;
            $display("FAIL R10 output-line toggle actual=%0d expected=0", changes_seen);
        end
        pin_in_i = 7'h2F; tick(1); pin_in_i = 7'h20; tick(1); pin_in_i = 7'h2F; tick(6);
        // R11: unused select codes change nothing; writes land next cycle.
        tag = "R11"; wr(3'd0, 8'h7F); wr(3'd4, 8'h0F);
        wr(3'd6, 8'h00); wr(3'd7, 8'hFF); tick(4);
        wr(3'd3, 8'h3C); tick(2);
        // R2: strap during reset makes every line an output.
        tag = "R2"; do_reset(1'b1); key_det_i = 6'b100010; tick(5);
        key_det_i = 6'b000000; tick(5);
        summary();
    end
endmodule